// File: doc/BRIEF.md
# Four-Channel PWM Generator with Fault Break

This block produces edge-aligned pulse-width-modulated waveforms on four channels that share one time base. A prescaler divides the input clock and drives an up-counter that wraps after a programmable reload value. Each channel compares the counter with its own compare value and drives a main output and a complementary output. Each output has its own polarity. Every output is gated by one main output enable.

Two fault (break) inputs are each filtered, given an active level, and enabled separately. When an enabled fault is seen, the main output enable clears and every output falls to its inactive level. It stays there until software sets the enable again.

Software controls the block through a plain register port. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. The port has no handshake and no back-pressure: every access completes in its cycle.

Top module: `pwm_brk_top`

Register map (word addresses):
- 0 control: bit 0 counter run, bit 1 reload preload, bit 2 main output enable.
- 1 event: writing bit 0 as 1 forces an update. This register reads 0.
- 2 prescaler.
- 3 reload.
- 4 channel configuration.
- 5 break configuration.
- 6 compare preload: bit n for channel n.
- 7 counter (read only).
- 8+n compare value of channel n.

## Requirements
- R1: The output period is (prescaler+1)·(reload+1) input clocks, and the active time is (prescaler+1)·compare clocks. The prescaler takes a new value only at an update.
- R2: A channel's reference is active while counter < compare. A compare value above the reload keeps it active all the time, and a compare of 0 keeps it inactive.
- R3: When control bit 1 is set, a new reload value waits for the next update. When it is clear, the new value applies at once. Writing event bit 0 clears the prescaler and the counter and loads every buffered value.
- R4: When compare-preload bit n is set, a new compare value for channel n waits for the next update. When it is clear, the new value applies at once.
- R5: In the channel configuration register, channel n uses four bits:
  - bit 4n: enable
  - bit 4n+1: polarity
  - bit 4n+2: complementary enable
  - bit 4n+3: complementary polarity

  Setting the polarity bit inverts the main output.
- R6: The complementary output is the inverse of the reference before polarity is applied, and the complementary polarity bit inverts it. With both polarity bits clear, the main and complementary outputs are never high together.
- R7: Each output sits at its inactive level, which equals its polarity bit, in these cases:
  - its enable bit is clear;
  - the main output enable is clear.
- R8: The counter advances only while control bit 0 is set. Its value can be read at address 7.
- R9: Break n is configured by three fields:
  - bit 8n: enable
  - bit 8n+1: active level
  - bits 8n+7..8n+4: filter code

  A disabled break input has no effect on the outputs.
- R10: Filter code N changes the accepted level of a break input only after N+1 consecutive equal samples that differ from it. Code 0 therefore accepts a single sample. The accepted level starts at 0 after reset.
- R11: An accepted active level on an enabled break clears the main output enable. A write to control bit 2 sets it again only while no enabled break input is at its active level.
- R12: After reset all registers, the counter and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 16 | Read data, combinational |
| brk_in | input | 2 | Fault inputs |
| oc_o | output | 4 | Main channel outputs |
| ocn_o | output | 4 | Complementary channel outputs |

## Verification
The duty and period tests count high cycles over whole periods with these settings:
- compare values below the reload, equal to 0, and above the reload, which separates the compare boundary cases;
- a non-zero prescaler, to show that both terms of the formula are applied.

The reload and compare preload tests freeze or restart the counter from a known point. That makes it possible to tell a buffered value from an immediate one by the final counter value or by the output level.

The break tests use pulses one sample shorter than, and equal to, the filter length. They also assert an input while it is disabled, and drive an active-low input. This separates filtering, level selection and enable gating.

// File: rtl/pwm_brk_pkg.sv
package pwm_brk_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_EVT    = 1;
  localparam int A_PSC    = 2;
  localparam int A_RELOAD = 3;
  localparam int A_CHCFG  = 4;
  localparam int A_BRKCFG = 5;
  localparam int A_CMPPRE = 6;
  localparam int A_COUNT  = 7;
  localparam int A_CMP0   = 8;

  localparam int CH_BITS  = 4;  // bits per channel in channel configuration
  localparam int BRK_BITS = 8;  // bits per break input in break configuration

  typedef struct packed {
    logic npol;
    logic nen;
    logic pol;
    logic en;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             arpe_i,
  input  logic             ug_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o
);
  logic [PSC_W-1:0] pcnt_q, psc_sh_q;
  logic [CNT_W-1:0] cnt_q, rl_sh_q, rl_eff;
  logic             tick, wrap;

  assign rl_eff = arpe_i ? rl_sh_q : reload_i;
  assign tick   = run_i && (pcnt_q == psc_sh_q);
  assign wrap   = tick && (cnt_q == rl_eff);
  assign upd_o  = ug_i || wrap;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q   <= '0;
      cnt_q    <= '0;
      psc_sh_q <= '0;
      rl_sh_q  <= '0;
    end else begin
      if (ug_i) begin
        pcnt_q <= '0;
        cnt_q  <= '0;
      end else if (run_i) begin
        if (tick) begin
          pcnt_q <= '0;
          cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
      if (upd_o) begin
        psc_sh_q <= psc_i;
        rl_sh_q  <= reload_i;
      end
    end
  end

  AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= psc_sh_q);                                          // R1
  AST_UPD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> (cnt_o == '0));                                     // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !ug_i) |=> $stable(cnt_o));                        // R8
endmodule

// File: rtl/pwm_brk_filter.sv
module pwm_brk_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [FILT_W-1:0] code_i,
  output logic              lvl_o
);
  logic              smp_q, lvl_q;
  logic [FILT_W-1:0] run_q;

  assign lvl_o = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      smp_q <= pin_i;
      if (smp_q == lvl_q) begin
        run_q <= '0;
      end else if (run_q >= code_i) begin
        lvl_q <= smp_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_q == lvl_q) |=> $stable(lvl_o));                         // R10
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [CNT_W-1:0]      cmp_i,
  input  logic                  pre_i,
  input  logic                  upd_i,
  input  pwm_brk_pkg::chan_cfg_t cfg_i,
  input  logic                  moe_i,
  output logic                  oc_o,
  output logic                  ocn_o
);
  logic [CNT_W-1:0] cmp_sh_q, cmp_eff;
  logic             ref_a;

  assign cmp_eff = pre_i ? cmp_sh_q : cmp_i;
  assign ref_a   = (cnt_i < cmp_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh_q <= '0;
      oc_o     <= 1'b0;
      ocn_o    <= 1'b0;
    end else begin
      if (upd_i) cmp_sh_q <= cmp_i;
      oc_o  <= (cfg_i.en  && moe_i &&  ref_a) ^ cfg_i.pol;
      ocn_o <= (cfg_i.nen && moe_i && !ref_a) ^ cfg_i.npol;
    end
  end

  AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.en || !moe_i) |=> (oc_o == $past(cfg_i.pol)));        // R7
  AST_COMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !(oc_o && ocn_o && !$past(cfg_i.pol) && !$past(cfg_i.npol))); // R6
endmodule

// File: rtl/pwm_brk_top.sv
module pwm_brk_top #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int NCH    = 4,
  parameter int NBRK   = 2,
  parameter int FILT_W = 4,
  parameter int ADDR_W = 4,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NBRK-1:0]   brk_in,
  output logic [NCH-1:0]    oc_o,
  output logic [NCH-1:0]    ocn_o
);
  import pwm_brk_pkg::*;

  localparam int CFG_W = CH_BITS * NCH;
  localparam int BRK_W = BRK_BITS * NBRK;

  logic                 run_q, arpe_q, moe_q;
  logic [PSC_W-1:0]     psc_q;
  logic [CNT_W-1:0]     reload_q;
  logic [CFG_W-1:0]     chcfg_q;
  logic [BRK_W-1:0]     brkcfg_q;
  logic [NCH-1:0]       cmppre_q;
  logic [CNT_W-1:0]     cmp_q [NCH];
  logic [CNT_W-1:0]     cnt;
  logic                 upd, ug, ctrl_wr;
  logic [NBRK-1:0]      brk_lvl, brk_hit;
  logic                 fault;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign ug      = wr_en && (wr_addr == ADDR_W'(A_EVT)) && wr_data[0];
  assign fault   = |brk_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      arpe_q   <= 1'b0;
      moe_q    <= 1'b0;
      psc_q    <= '0;
      reload_q <= '0;
      chcfg_q  <= '0;
      brkcfg_q <= '0;
      cmppre_q <= '0;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
    end else begin
      if (fault)        moe_q <= 1'b0;
      else if (ctrl_wr) moe_q <= wr_data[2];
      if (ctrl_wr) begin
        run_q  <= wr_data[0];
        arpe_q <= wr_data[1];
      end
      if (wr_en) begin
        if (wr_addr == ADDR_W'(A_PSC))    psc_q    <= wr_data[PSC_W-1:0];
        if (wr_addr == ADDR_W'(A_RELOAD)) reload_q <= wr_data[CNT_W-1:0];
        if (wr_addr == ADDR_W'(A_CHCFG))  chcfg_q  <= wr_data[CFG_W-1:0];
        if (wr_addr == ADDR_W'(A_BRKCFG)) brkcfg_q <= wr_data[BRK_W-1:0];
        if (wr_addr == ADDR_W'(A_CMPPRE)) cmppre_q <= wr_data[NCH-1:0];
        for (int i = 0; i < NCH; i++)
          if (wr_addr == ADDR_W'(A_CMP0 + i)) cmp_q[i] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      A_CTRL:   rd_data[2:0] = {moe_q, arpe_q, run_q};
      A_PSC:    rd_data[PSC_W-1:0] = psc_q;
      A_RELOAD: rd_data[CNT_W-1:0] = reload_q;
      A_CHCFG:  rd_data[CFG_W-1:0] = chcfg_q;
      A_BRKCFG: rd_data[BRK_W-1:0] = brkcfg_q;
      A_CMPPRE: rd_data[NCH-1:0]   = cmppre_q;
      A_COUNT:  rd_data[CNT_W-1:0] = cnt;
      default:  rd_data = '0;
    endcase
    for (int i = 0; i < NCH; i++)
      if (int'(rd_addr) == A_CMP0 + i) rd_data[CNT_W-1:0] = cmp_q[i];
  end

  pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .arpe_i(arpe_q), .ug_i(ug),
    .psc_i(psc_q), .reload_i(reload_q), .cnt_o(cnt), .upd_o(upd)
  );

  for (genvar b = 0; b < NBRK; b++) begin : g_brk
    pwm_brk_filter #(.FILT_W(FILT_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .pin_i(brk_in[b]),
      .code_i(brkcfg_q[BRK_BITS*b+4 +: FILT_W]), .lvl_o(brk_lvl[b])
    );
    assign brk_hit[b] = brkcfg_q[BRK_BITS*b] &&
                        (brk_lvl[b] == brkcfg_q[BRK_BITS*b+1]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cmp_i(cmp_q[c]),
      .pre_i(cmppre_q[c]), .upd_i(upd),
      .cfg_i(chan_cfg_t'(chcfg_q[CH_BITS*c +: CH_BITS])),
      .moe_i(moe_q), .oc_o(oc_o[c]), .ocn_o(ocn_o[c])
    );
  end

  AST_BRK_CLEARS_MOE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !moe_q);                                            // R11
  AST_MOE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moe_q) |-> $past(ctrl_wr && wr_data[2]));               // R11
endmodule

// File: tb/pwm_brk_top_tb_top.sv
module pwm_brk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  brk_in = 2'b10;
  logic [3:0]  oc_o, ocn_o;

  int n_chk = 0, n_fail = 0;
  int hi_oc [4];
  int hi_ocn[4];
  int rises0, both0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_brk_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .brk_in(brk_in), .oc_o(oc_o), .ocn_o(ocn_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 4'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic measure(input int win);
    logic prev;
    for (int c = 0; c < 4; c++) begin hi_oc[c] = 0; hi_ocn[c] = 0; end
    rises0 = 0; both0 = 0;
    prev = oc_o[0];
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        hi_oc[c]  += int'(oc_o[c]);
        hi_ocn[c] += int'(ocn_o[c]);
      end
      if (oc_o[0] && !prev) rises0++;
      if (oc_o[0] && ocn_o[0]) both0++;
      prev = oc_o[0];
    end
  endtask

  task automatic pulse0(input int len);
    brk_in[0] = 1'b1;
    repeat (len) @(negedge clk);
    brk_in[0] = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic int moe_of(input int ctrl);
    return (ctrl >> 2) & 1;
  endfunction

  task automatic t_reset();
    int d;
    chk("R12 oc after reset", int'(oc_o), 0);
    chk("R12 ocn after reset", int'(ocn_o), 0);
    rd(0, d); chk("R12 control after reset", d, 0);
    rd(7, d); chk("R12 counter after reset", d, 0);
  endtask

  task automatic t_duty();
    wr(2, 0); wr(3, 9);
    wr(8, 3); wr(9, 0); wr(10, 10); wr(11, 5);
    wr(4, 16'h1111);
    wr(1, 1); wr(0, 5);
    repeat (5) @(negedge clk);
    measure(100);
    chk("R1 ch0 active cycles", hi_oc[0], 30);
    chk("R2 ch1 compare 0 never active", hi_oc[1], 0);
    chk("R2 ch2 compare above reload always active", hi_oc[2], 100);
    chk("R1 ch3 active cycles", hi_oc[3], 50);
  endtask

  task automatic t_prescale();
    wr(2, 2); wr(3, 4); wr(8, 2); wr(1, 1);
    repeat (5) @(negedge clk);
    measure(150);
    chk("R1 prescaled active cycles", hi_oc[0], 60);
    chk("R1 prescaled period count", rises0, 10);
  endtask

  task automatic t_polarity();
    wr(2, 0); wr(3, 9); wr(8, 3); wr(9, 3); wr(10, 10); wr(1, 1);
    // ch0 en+nen, ch1 en+pol, ch2 en, ch3 pol only (disabled)
    wr(4, 16'h2135);
    repeat (5) @(negedge clk);
    measure(100);
    chk("R6 complementary active cycles", hi_ocn[0], 70);
    chk("R6 never both high", both0, 0);
    chk("R5 inverted ch1", hi_oc[1], 70);
    chk("R7 disabled ch3 at polarity level", hi_oc[3], 100);
    chk("R6 complementary disabled ch1", hi_ocn[1], 0);
    wr(4, 16'h213D);
    repeat (5) @(negedge clk);
    measure(100);
    chk("R6 complementary polarity inverts", hi_ocn[0], 30);
    wr(0, 1);
    repeat (5) @(negedge clk);
    measure(20);
    chk("R7 moe clear ch1 at polarity level", hi_oc[1], 20);
    chk("R7 moe clear ch2 low", hi_oc[2], 0);
    chk("R7 moe clear ch0n at polarity level", hi_ocn[0], 20);
    wr(4, 16'h1111);
  endtask

  task automatic t_reload_preload();
    int d;
    wr(0, 6); wr(2, 0); wr(3, 9); wr(1, 1); wr(3, 19);
    wr(0, 7);
    repeat (14) @(negedge clk);
    wr(0, 6);
    rd(7, d); chk("R3 buffered reload waits for update", d, 5);
    repeat (20) @(negedge clk);
    rd(7, d); chk("R8 counter frozen when run clear", d, 5);
    wr(0, 4); wr(3, 9); wr(1, 1); wr(3, 19);
    wr(0, 5);
    repeat (14) @(negedge clk);
    wr(0, 4);
    rd(7, d); chk("R3 unbuffered reload applies at once", d, 15);
    rd(1, d); chk("R3 event register reads 0", d, 0);
  endtask

  task automatic t_cmp_preload();
    wr(0, 4); wr(3, 9); wr(8, 0); wr(1, 1);
    wr(6, 1); wr(8, 5);
    repeat (3) @(negedge clk);
    chk("R4 buffered compare held", int'(oc_o[0]), 0);
    wr(1, 1);
    repeat (3) @(negedge clk);
    chk("R4 buffered compare loaded at update", int'(oc_o[0]), 1);
    wr(6, 0); wr(8, 0);
    repeat (3) @(negedge clk);
    chk("R4 unbuffered compare immediate", int'(oc_o[0]), 0);
  endtask

  task automatic t_break();
    int d;
    wr(8, 3); wr(10, 10); wr(3, 9); wr(1, 1); wr(0, 5);
    wr(5, 0);
    pulse0(10);
    rd(0, d); chk("R9 disabled break ignored", moe_of(d), 1);
    wr(5, 16'h0133);
    repeat (4) @(negedge clk);
    pulse0(3);
    rd(0, d); chk("R10 pulse shorter than filter ignored", moe_of(d), 1);
    pulse0(4);
    rd(0, d); chk("R11 filtered break clears enable", moe_of(d), 0);
    measure(20);
    chk("R11 outputs inactive after break", hi_oc[2], 0);
    brk_in[0] = 1'b1;
    repeat (8) @(negedge clk);
    wr(0, 5);
    repeat (2) @(negedge clk);
    rd(0, d); chk("R11 set refused while fault present", moe_of(d), 0);
    brk_in[0] = 1'b0;
    repeat (10) @(negedge clk);
    wr(0, 5);
    repeat (3) @(negedge clk);
    rd(0, d); chk("R11 set accepted after fault clears", moe_of(d), 1);
    measure(20);
    chk("R11 outputs active again", hi_oc[2], 20);
    brk_in[1] = 1'b0;
    @(negedge clk);
    brk_in[1] = 1'b1;
    repeat (6) @(negedge clk);
    rd(0, d); chk("R9 active-low break with code 0 trips", moe_of(d), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_duty();
    t_prescale();
    t_polarity();
    t_reload_preload();
    t_cmp_preload();
    t_break();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule